// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address, beat by beat, for one SDRAM read or write burst. A small mode word sets the burst length, the ordering of columns inside the burst and the CAS latency. Commands arrive already decoded, one per clock: read, write, burst stop and precharge of the bank in use. The block then steps the column every clock and raises a flag on the final beat of a fixed-length burst. It also marks, CAS latency cycles later, the clocks in which read data is valid on the data bus.

Bursts can be sequential or interleaved, and a full-page burst wraps around the page with no end of its own. A burst ends early on a stop, on a precharge, or on a new read or write. A new read or write may arrive on any clock. A burst issued with auto-precharge cannot be cut short by a precharge or by a new column command. Such commands are refused and the refusal is flagged. A precharge that cuts a write short asserts the data mask for one clock to cover write recovery.

Top module: `sdram_burst_seq`

## Requirements
- R1: After synchronous reset the block is idle: busy, last_beat, rd_valid, wr_mask, cmd_reject and mode_err are 0, and the mode is length 1, sequential, CAS latency 2.
- R2: mode_word is taken when mode_load is high and busy is low. Bits [2:0] code the length (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 selects interleaved order and bit 4 selects CAS latency 3 (0 gives latency 2). While busy, mode_load is ignored.
- R3: Length codes 100, 101 and 110 are reserved and set mode_err from the next clock on. While mode_err is set, a read or write starts no burst and raises cmd_reject for one clock, the clock after the command.
- R4: cmd_op codes are 0 idle, 1 read, 2 write. A read or write from idle brings busy high and puts the start column on col_out on the next clock. In sequential order, beat k keeps the column bits above log2(length) and sets the low log2(length) bits to (start + k) mod length. busy stays high for exactly the burst length, and last_beat marks the final beat.
- R5: With interleaved order at length 4 or 8, the low log2(length) bits of beat k are the start's low bits XOR k. At lengths 1 and 2 the order is the same as sequential.
- R6: A full-page burst gives column (start + k) mod 2^COL_W, wraps past the top of the page, never raises last_beat and stays busy until it is ended.
- R7: A read or write during a burst that has no auto-precharge ends that burst. The new start column shows on col_out on the next clock, so a new command may be given on every clock.
- R8: Burst stop (cmd_op 3) during a burst drops busy on the next clock. The beat of the clock in which the stop is given is not read. Read data stays valid for 1 more clock after the stop clock at CAS latency 2, and for 2 more clocks at CAS latency 3.
- R9: Precharge (cmd_op 4) during a burst without auto-precharge ends it the same way as a stop. If the burst is a write, wr_mask is high for exactly the next clock.
- R10: During a burst started with cmd_autopre high, a precharge or a new read or write is refused. cmd_reject goes high on the next clock and the burst continues unchanged.
- R11: rd_valid is high exactly CAS latency clocks after each clock in which a read beat is shown, and is never high for write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load mode_word (taken only when idle) |
| mode_word | input | 5 | [2:0] length code, [3] interleave, [4] CAS latency 3 |
| cmd_op | input | 3 | 0 idle, 1 read, 2 write, 3 stop, 4 precharge |
| cmd_col | input | COL_W | Start column of a read or write |
| cmd_autopre | input | 1 | Read or write carries auto-precharge |
| busy | output | 1 | A burst beat is shown on col_out |
| col_out | output | COL_W | Column of the current beat |
| last_beat | output | 1 | Current beat is the final beat of a fixed-length burst |
| wr_burst | output | 1 | Current burst is a write |
| rd_valid | output | 1 | Read data valid on the bus this clock |
| wr_mask | output | 1 | Data mask for write recovery after a precharge |
| cmd_reject | output | 1 | The previous clock's command was refused |
| mode_err | output | 1 | Loaded length code is reserved |

## Verification
Directed bursts start at columns that are not aligned to the burst length. This separates wrap within the aligned block from a plain increment, and it separates XOR ordering from sequential ordering at lengths 4 and 8 while showing that the two orders match at length 2. A full-page burst starting near the top of the page shows the wrap across the page end. Stops and precharges are tried at both CAS latencies, which tells the one-clock read tail from the two-clock tail and tells a read from a write with its mask. Auto-precharge bursts show refusal against early termination. Seeded random command streams with mode changes then mix restarts on consecutive clocks with the other cases, and a bench reference model checks every clock.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_STOP  = 3'd3,
    OP_PRECH = 3'd4
  } seq_op_e;

  localparam logic [2:0] LEN_FULL = 3'b111;
endpackage

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  output logic [COL_W-1:0] col,
  output logic [COL_W-1:0] len_mask
);
  logic             use_xor;
  logic [COL_W-1:0] low_part;

  always_comb begin
    case (len_code)
      3'b000:  len_mask = COL_W'(0);
      3'b001:  len_mask = COL_W'(1);
      3'b010:  len_mask = COL_W'(3);
      3'b011:  len_mask = COL_W'(7);
      default: len_mask = '1;
    endcase
    // XOR order only matters for 4- and 8-beat bursts
    use_xor  = interleave && (len_code == 3'b010 || len_code == 3'b011);
    low_part = use_xor ? (start_col ^ beat) : (start_col + beat);
    col      = (start_col & ~len_mask) | (low_part & len_mask);
  end
endmodule

// File: rtl/cas_tail.sv
module cas_tail #(
  parameter int MAX_CL = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic cl_long,
  output logic valid
);
  logic [MAX_CL-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[MAX_CL-2:0], issue};
  end

  assign valid = cl_long ? pipe[MAX_CL-1] : pipe[MAX_CL-2];
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_load,
  input  logic [4:0]       mode_word,
  input  logic [2:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_autopre,
  output logic             busy,
  output logic [COL_W-1:0] col_out,
  output logic             last_beat,
  output logic             wr_burst,
  output logic             rd_valid,
  output logic             wr_mask,
  output logic             cmd_reject,
  output logic             mode_err
);
  logic [2:0]       bl_q;
  logic             il_q, cl3_q, ap_q;
  logic [COL_W-1:0] start_q, cnt_q;

  logic             busy_n, wr_n, ap_n;
  logic [COL_W-1:0] start_n, cnt_n, col_n, len_mask;

  seq_op_e op;
  logic    is_col, ap_block, accept, refuse, halt, full_page, issue;

  assign op        = seq_op_e'(cmd_op);
  assign is_col    = (op == OP_READ) || (op == OP_WRITE);
  assign ap_block  = busy && ap_q;
  assign accept    = is_col && !mode_err && !ap_block;
  assign refuse    = (is_col && (mode_err || ap_block)) || (op == OP_PRECH && ap_block);
  assign halt      = busy && ((op == OP_STOP) || (op == OP_PRECH && !ap_q));
  assign full_page = (bl_q == LEN_FULL);
  assign issue     = busy && !wr_burst && !halt;

  always_comb begin
    busy_n  = busy;
    start_n = start_q;
    cnt_n   = cnt_q;
    wr_n    = wr_burst;
    ap_n    = ap_q;
    if (accept) begin
      busy_n  = 1'b1;
      start_n = cmd_col;
      cnt_n   = '0;
      wr_n    = (op == OP_WRITE);
      ap_n    = cmd_autopre;
    end else if (halt) begin
      busy_n = 1'b0;
      ap_n   = 1'b0;
    end else if (busy) begin
      if (!full_page && cnt_q == len_mask) begin
        busy_n = 1'b0;
        ap_n   = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  burst_col_gen #(.COL_W(COL_W)) u_gen (
    .start_col (start_n),
    .beat      (cnt_n),
    .len_code  (bl_q),
    .interleave(il_q),
    .col       (col_n),
    .len_mask  (len_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      start_q    <= '0;
      cnt_q      <= '0;
      col_out    <= '0;
      last_beat  <= 1'b0;
      wr_burst   <= 1'b0;
      ap_q       <= 1'b0;
      wr_mask    <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      busy       <= busy_n;
      start_q    <= start_n;
      cnt_q      <= cnt_n;
      wr_burst   <= wr_n;
      ap_q       <= ap_n;
      if (busy_n) col_out <= col_n;
      last_beat  <= busy_n && !full_page && (cnt_n == len_mask);
      wr_mask    <= halt && wr_burst && (op == OP_PRECH);
      cmd_reject <= refuse;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bl_q     <= 3'b000;
      il_q     <= 1'b0;
      cl3_q    <= 1'b0;
      mode_err <= 1'b0;
    end else if (mode_load && !busy) begin
      bl_q     <= mode_word[2:0];
      il_q     <= mode_word[3];
      cl3_q    <= mode_word[4];
      mode_err <= mode_word[2] && !(mode_word[1] && mode_word[0]);
    end
  end

  cas_tail #(.MAX_CL(MAX_CL)) u_tail (
    .clk    (clk),
    .rst    (rst),
    .issue  (issue),
    .cl_long(cl3_q),
    .valid  (rd_valid)
  );
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd_op,
  input logic             busy,
  input logic             last_beat,
  input logic             cmd_reject,
  input logic             mode_err,
  input logic             wr_mask,
  input logic [COL_W-1:0] col_out,
  input logic [2:0]       bl_q,
  input logic             ap_q
);
  a_r4_last_in_burst: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> busy);

  a_r4_block_kept: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_beat && bl_q == 3'b011 && cmd_op == 3'd0)
      |=> (busy && col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_op == 3'd3) |=> !busy);

  a_r3_reserved_refused: assert property (@(posedge clk) disable iff (rst)
    (mode_err && !busy && (cmd_op == 3'd1 || cmd_op == 3'd2)) |=> (!busy && cmd_reject));

  a_r6_full_page_runs: assert property (@(posedge clk) disable iff (rst)
    (busy && bl_q == 3'b111 && cmd_op == 3'd0) |=> (busy && !last_beat));

  a_r10_ap_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && ap_q && !last_beat && cmd_op == 3'd4) |=> (busy && cmd_reject));

  a_r9_mask_single: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> !wr_mask);
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .last_beat (last_beat),
  .cmd_reject(cmd_reject),
  .mode_err  (mode_err),
  .wr_mask   (wr_mask),
  .col_out   (col_out),
  .bl_q      (bl_q),
  .ap_q      (ap_q)
);

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;
  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0, rst = 1'b1, mode_load = 1'b0, cmd_autopre = 1'b0;
  logic [4:0]       mode_word = '0;
  logic [2:0]       cmd_op = '0;
  logic [COL_W-1:0] cmd_col = '0;
  logic             busy, last_beat, wr_burst, rd_valid, wr_mask, cmd_reject, mode_err;
  logic [COL_W-1:0] col_out;

  always #4 clk = ~clk;

  sdram_burst_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .cmd_op(cmd_op), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
    .busy(busy), .col_out(col_out), .last_beat(last_beat), .wr_burst(wr_burst),
    .rd_valid(rd_valid), .wr_mask(wr_mask), .cmd_reject(cmd_reject), .mode_err(mode_err)
  );

  int n_chk = 0, n_fail = 0;

  // reference model state
  bit m_busy, m_wr, m_ap, m_il, m_cl3, m_err, m_rej, m_mask, m_last;
  int m_bl, m_start, m_cnt;
  bit h0, h1, h2;

  function automatic int blen(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return PAGE;
    endcase
  endfunction

  function automatic int exp_col(int s, int k, int code, bit il);
    int len, base, lo;
    len = blen(code);
    if (len == PAGE) return (s + k) % PAGE;
    base = s - (s % len);
    lo   = s % len;
    if (il && len >= 4) return base + (lo ^ (k % len));
    return base + ((lo + k) % len);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit col_cmd, blk, acc, halt, issue, pb;
    int op;
    op      = int'(cmd_op);
    pb      = m_busy;
    col_cmd = (op == 1) || (op == 2);
    blk     = m_busy && m_ap;
    acc     = col_cmd && !m_err && !blk;
    halt    = m_busy && (op == 3 || (op == 4 && !m_ap));
    issue   = m_busy && !m_wr && !halt;
    m_rej   = (col_cmd && (m_err || blk)) || (op == 4 && blk);
    m_mask  = halt && m_wr && (op == 4);
    h2 = h1; h1 = h0; h0 = issue;
    if (acc) begin
      m_busy = 1; m_start = int'(cmd_col); m_cnt = 0; m_wr = (op == 2); m_ap = cmd_autopre;
    end else if (halt) begin
      m_busy = 0; m_ap = 0;
    end else if (m_busy) begin
      if (blen(m_bl) < PAGE && m_cnt == blen(m_bl) - 1) begin
        m_busy = 0; m_ap = 0;
      end else begin
        m_cnt = (m_cnt + 1) % PAGE;
      end
    end
    m_last = m_busy && blen(m_bl) < PAGE && m_cnt == blen(m_bl) - 1;
    if (mode_load && !pb) begin
      m_bl  = int'(mode_word[2:0]);
      m_il  = mode_word[3];
      m_cl3 = mode_word[4];
      m_err = (m_bl == 4 || m_bl == 5 || m_bl == 6);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "busy", int'(busy), int'(m_busy));
    if (m_busy) begin
      chk(tag, "col_out", int'(col_out), exp_col(m_start, m_cnt, m_bl, m_il));
      chk(tag, "wr_burst", int'(wr_burst), int'(m_wr));
    end
    chk(tag, "last_beat", int'(last_beat), int'(m_last));
    chk(tag, "rd_valid", int'(rd_valid), int'(m_cl3 ? h2 : h1));
    chk(tag, "wr_mask", int'(wr_mask), int'(m_mask));
    chk(tag, "cmd_reject", int'(cmd_reject), int'(m_rej));
    chk(tag, "mode_err", int'(mode_err), int'(m_err));
  endtask

  task automatic step(int op, int col, bit ap, string tag);
    cmd_op      = 3'(op);
    cmd_col     = COL_W'(col);
    cmd_autopre = ap;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    mode_load   = 1'b0;
    cmd_op      = 3'd0;
    cmd_autopre = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  task automatic set_mode(int w, string tag);
    mode_load = 1'b1;
    mode_word = 5'(w);
    step(0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "last_beat", int'(last_beat), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "wr_mask", int'(wr_mask), 0);
    chk("R1", "cmd_reject", int'(cmd_reject), 0);
    chk("R1", "mode_err", int'(mode_err), 0);
    step(1, 8'h21, 0, "R1");   // default length 1
    idle(4, "R1");

    // R4 sequential length 8, unaligned start
    set_mode(5'b00011, "R2");
    step(1, 8'h35, 0, "R4");
    idle(10, "R4");
    // R2 mode load ignored while busy
    step(1, 8'h06, 0, "R2");
    set_mode(5'b00000, "R2");
    idle(9, "R2");

    // R5 interleave lengths 4, 8, 2
    set_mode(5'b01010, "R5");
    step(1, 8'h0E, 0, "R5");
    idle(6, "R5");
    set_mode(5'b01011, "R5");
    step(2, 8'h2D, 0, "R11");
    idle(9, "R11");
    set_mode(5'b01001, "R5");
    step(1, 8'h13, 0, "R5");
    idle(4, "R5");

    // R6 full page wrap
    set_mode(5'b00111, "R6");
    step(1, 8'hFC, 0, "R6");
    idle(10, "R6");
    step(3, 0, 0, "R8");
    idle(4, "R8");

    // R8 stop at CAS latency 3 and 2
    set_mode(5'b10011, "R8");
    step(1, 8'h40, 0, "R8");
    idle(3, "R8");
    step(3, 0, 0, "R8");
    idle(4, "R8");
    set_mode(5'b00011, "R8");
    step(1, 8'h44, 0, "R8");
    idle(2, "R8");
    step(3, 0, 0, "R8");
    idle(4, "R8");

    // R9 precharge on read and on write
    step(1, 8'h10, 0, "R9");
    idle(2, "R9");
    step(4, 0, 0, "R9");
    idle(3, "R9");
    step(2, 8'h20, 0, "R9");
    idle(2, "R9");
    step(4, 0, 0, "R9");
    idle(3, "R9");

    // R7 new column every clock
    for (int i = 0; i < 6; i++) step(1, int'($urandom % PAGE), 0, "R7");
    step(2, 8'h77, 0, "R7");
    step(1, 8'h9A, 0, "R7");
    idle(10, "R7");

    // R10 auto-precharge bursts refuse interrupts
    step(1, 8'h50, 1, "R10");
    idle(1, "R10");
    step(4, 0, 0, "R10");
    step(1, 8'h60, 0, "R10");
    step(2, 8'h61, 0, "R10");
    idle(8, "R10");

    // R3 reserved lengths
    set_mode(5'b00100, "R3");
    step(1, 8'h11, 0, "R3");
    idle(3, "R3");
    set_mode(5'b00110, "R3");
    step(2, 8'h12, 0, "R3");
    idle(3, "R3");
    set_mode(5'b00101, "R3");
    step(1, 8'h13, 0, "R3");
    idle(2, "R3");
    set_mode(5'b10010, "R3");
    idle(2, "R3");

    // seeded random mix
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = int'($urandom % 12);
      if (sel < 5) step(0, 0, 0, "R7");
      else if (sel == 5 || sel == 10) step(1, int'($urandom % PAGE), ($urandom % 4) == 0, "R7");
      else if (sel == 6) step(2, int'($urandom % PAGE), ($urandom % 4) == 0, "R7");
      else if (sel == 7) step(3, 0, 0, "R8");
      else if (sel == 8) step(4, 0, 0, "R9");
      else if (sel == 9) begin
        int w;
        w = int'($urandom % 32);
        if ((w % 8) >= 4 && (w % 8) != 7 && ($urandom % 3) != 0) w = w - 4;
        set_mode(w, "R2");
      end else step(0, 0, 0, "R11");
    end
    idle(5, "R11");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule